// File: doc/BRIEF.md
# Slow Flash Window Target for a PCI Bus

This block is a PCI bus target that places a slow, asynchronous parallel flash behind a 128 KB window in memory space. It watches each address phase. It claims memory reads and memory writes whose upper address bits match a window base, using medium decode timing. It then runs a single flash access with a fixed number of wait clocks. It ends the data phase with TRDY# and STOP# asserted together, so that every transaction, including any burst an initiator starts, moves exactly one data item.

On the flash side the block presents a 16-bit word interface: a word address, write data with its own output enable, read data, and active-low chip enable, output enable and one write enable per byte lane. The 32-bit PCI data path maps to one flash word per access. The byte enables choose the lower or the upper half of the dword, and within that half they choose the bytes that are written.

Top module: `pcif_flash_bridge`

## Requirements
- R1: While reset is asserted and after its release, DEVSEL#, TRDY# and STOP# are high, the AD output enable is low, and the flash chip enable, output enable and both write enables are high.
- R2: A cycle is claimed only when the address phase carries command 4'b0110 (memory read) or 4'b0111 (memory write) on C/BE# and AD[31:17] equals `win_base`. Any other command or address leaves DEVSEL# high and the flash chip enable high for the whole cycle.
- R3: For a claimed cycle, DEVSEL# is still high on the clock after the address phase and goes low on the second clock after it (medium decode).
- R4: TRDY# first goes low LAT+1 clocks after the first data-phase clock on a read. On a write it first goes low LAT+1 clocks after the first data-phase clock in which IRDY# is low. LAT defaults to 6 and must be at least 3.
- R5: STOP# is low in exactly the clocks in which TRDY# is low. Every transaction carries one data transfer, and DEVSEL# stays high after it until a new address phase.
- R6: While TRDY# is low and IRDY# is high, TRDY#, STOP# and the read data hold. The transfer completes on the first clock in which both are low.
- R7: On the clock after the transfer completes, DEVSEL#, TRDY# and STOP# are high and AD is no longer driven. Once FRAME# is high, a new address phase is claimed.
- R8: A read returns the flash word at word address {AD[16:2], h}, where h = 1 when C/BE#[1:0] = 2'b11 and h = 0 otherwise. The word appears on AD[31:16] when h = 1 and on AD[15:0] when h = 0, the other half is zero, and AD is driven only in clocks where TRDY# is low.
- R9: A write stores into flash word {AD[16:2], h} with the same rule for h. Write enable bit 0 covers byte enable 0 (h = 0) or byte enable 2 (h = 1), and bit 1 covers byte enable 1 or 3. Only lanes whose byte enable is low pulse, each for LAT-2 clocks, with address and data held across the pulse. Bytes whose enable is high keep their previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_base | input | 15 | Window base, compared with AD[31:17]; held static |
| frame_n | input | 1 | FRAME# from the initiator |
| irdy_n | input | 1 | IRDY# from the initiator |
| cbe_n | input | 4 | C/BE#: command in the address phase, byte enables in the data phase |
| ad_i | input | 32 | AD bus as seen by the target |
| ad_o | output | 32 | Read data driven onto AD |
| ad_oe | output | 1 | Enable for the AD drivers |
| devsel_n | output | 1 | DEVSEL# |
| trdy_n | output | 1 | TRDY# |
| stop_n | output | 1 | STOP# |
| fl_addr | output | 16 | Flash word address |
| fl_dq_o | output | 16 | Flash write data |
| fl_dq_oe | output | 1 | Enable for the flash data drivers |
| fl_dq_i | input | 16 | Flash read data |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 2 | Flash write enables per byte lane, active low |

## Verification
The assertions assume a well-behaved initiator. FRAME# is high on the clock before each address phase. IRDY# stays low once it has been asserted in a data phase, until the transfer completes. The byte enables and write data are stable from the first data-phase clock, and `win_base` does not change. The bench initiator keeps to these rules. It drives each address phase after an idle clock, puts the byte enables and write data out on the first data-phase clock, and holds IRDY# low from the clock it first asserts it until it sees the transfer complete. It deliberately holds FRAME# low through the whole data phase, so that the disconnect, rather than the initiator, ends every cycle.

// File: rtl/pcif_pkg.sv
package pcif_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_WAIT,
    ST_XFER,
    ST_DONE
  } bstate_t;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  // Only plain memory read and write are claimed.
  function automatic logic cmd_claimable(input logic [3:0] cmd);
    return (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
  endfunction

  // The upper half is selected only when both lower lanes are disabled.
  function automatic logic upper_half(input logic [3:0] be_n);
    return be_n[1] & be_n[0];
  endfunction

  // Active-high lane enables within the selected half: bit0 = low byte.
  function automatic logic [1:0] lane_enables(input logic [3:0] be_n, input logic hi);
    return hi ? ~be_n[3:2] : ~be_n[1:0];
  endfunction

  // Place a flash word on its half of the dword; the other half reads zero.
  function automatic logic [31:0] place_word(input logic [15:0] w, input logic hi);
    return hi ? {w, 16'h0000} : {16'h0000, w};
  endfunction

endpackage

// File: rtl/pcif_decode.sv
module pcif_decode
  import pcif_pkg::*;
#(
  parameter int WIN_AW = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [31-WIN_AW:0] ad_hi,
  input  logic [3:0]        cbe_n,
  input  logic [31-WIN_AW:0] win_base,
  input  logic              idle,
  output logic              addr_phase,
  output logic              claim,
  output logic              claim_wr
);

  logic frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= 1'b1;
    else        frame_q <= frame_n;
  end

  // An address phase is the first clock with FRAME# low.
  assign addr_phase = frame_q && !frame_n;
  assign claim      = addr_phase && idle && (ad_hi == win_base) && cmd_claimable(cbe_n);
  assign claim_wr   = (cbe_n == CMD_MEM_WR);

endmodule

// File: rtl/pcif_wait_ctr.sv
module pcif_wait_ctr #(
  parameter int LAT = 6,
  parameter int CW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [CW-1:0] cnt,
  output logic          done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (!done) cnt <= cnt + CW'(1);
  end

  assign done = run && (cnt == CW'(LAT - 1));

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LAT - 1));

endmodule

// File: rtl/pcif_flash_port.sv
module pcif_flash_port
  import pcif_pkg::*;
#(
  parameter int DW_AW = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             is_wr,
  input  logic             wr_pulse,
  input  logic             hi,
  input  logic [DW_AW-1:0] dw_addr,
  input  logic [31:0]      wdata,
  input  logic [3:0]       be_n,
  output logic [DW_AW:0]   fl_addr,
  output logic [15:0]      fl_dq_o,
  output logic             fl_dq_oe,
  output logic             fl_ce_n,
  output logic             fl_oe_n,
  output logic [1:0]       fl_we_n
);

  logic we_any;

  assign fl_addr  = {dw_addr, hi};
  assign fl_dq_o  = hi ? wdata[31:16] : wdata[15:0];
  assign fl_dq_oe = active && is_wr;
  assign fl_ce_n  = !active;
  assign fl_oe_n  = !(active && !is_wr);
  assign fl_we_n  = ~(lane_enables(be_n, hi) & {2{wr_pulse}});
  assign we_any   = !(&fl_we_n);

  // R9
  we_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_any |-> (!fl_ce_n && fl_oe_n && fl_dq_oe));

  // R9
  we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_any && $past(we_any)) |-> ($stable(fl_dq_o) && $stable(fl_addr)));

endmodule

// File: rtl/pcif_flash_bridge.sv
module pcif_flash_bridge
  import pcif_pkg::*;
#(
  parameter int WIN_AW = 17,
  parameter int LAT    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [31-WIN_AW:0]  win_base,
  input  logic                frame_n,
  input  logic                irdy_n,
  input  logic [3:0]          cbe_n,
  input  logic [31:0]         ad_i,
  output logic [31:0]         ad_o,
  output logic                ad_oe,
  output logic                devsel_n,
  output logic                trdy_n,
  output logic                stop_n,
  output logic [WIN_AW-2:0]   fl_addr,
  output logic [15:0]         fl_dq_o,
  output logic                fl_dq_oe,
  input  logic [15:0]         fl_dq_i,
  output logic                fl_ce_n,
  output logic                fl_oe_n,
  output logic [1:0]          fl_we_n
);

  localparam int DW_AW = WIN_AW - 2;
  localparam int CW    = $clog2(LAT + 1);

  bstate_t          state_q, state_d;
  logic             addr_phase, claim, claim_wr;
  logic             is_wr_q, ready_q;
  logic [DW_AW-1:0] dw_q;
  logic [3:0]       be_q;
  logic [31:0]      wdata_q;
  logic [15:0]      rdata_q;
  logic [CW-1:0]    cnt;

  // Named internal events
  logic in_wait, in_xfer, wait_run, wait_done, xfer_done, capture_wr, late_ready;
  logic hi_sel, wr_pulse, fl_active;

  pcif_decode #(.WIN_AW(WIN_AW)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .ad_hi     (ad_i[31:WIN_AW]),
    .cbe_n     (cbe_n),
    .win_base  (win_base),
    .idle      (state_q == ST_IDLE),
    .addr_phase(addr_phase),
    .claim     (claim),
    .claim_wr  (claim_wr)
  );

  assign in_wait    = (state_q == ST_WAIT);
  assign in_xfer    = (state_q == ST_XFER);
  assign wait_run   = in_wait && ready_q;
  assign late_ready = in_wait && !ready_q && !irdy_n;
  assign capture_wr = is_wr_q && !irdy_n && ((state_q == ST_DECODE) || late_ready);
  assign xfer_done  = in_xfer && !irdy_n;

  pcif_wait_ctr #(.LAT(LAT), .CW(CW)) u_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (wait_run),
    .cnt  (cnt),
    .done (wait_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (claim) state_d = ST_DECODE;
      ST_DECODE: state_d = ST_WAIT;
      ST_WAIT:   if (wait_done) state_d = ST_XFER;
      ST_XFER:   if (!irdy_n) state_d = ST_DONE;
      ST_DONE:   if (frame_n) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      is_wr_q <= 1'b0;
      ready_q <= 1'b0;
      dw_q    <= '0;
      be_q    <= 4'hF;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (claim) begin
        dw_q    <= ad_i[WIN_AW-1:2];
        is_wr_q <= claim_wr;
      end
      if (state_q == ST_DECODE) begin
        be_q    <= cbe_n;
        ready_q <= !is_wr_q || !irdy_n;
      end else if (late_ready) begin
        be_q    <= cbe_n;
        ready_q <= 1'b1;
      end else if (state_q == ST_IDLE) begin
        ready_q <= 1'b0;
      end
      if (capture_wr) wdata_q <= ad_i;
      if (wait_done && !is_wr_q) rdata_q <= fl_dq_i;
    end
  end

  assign hi_sel    = upper_half(be_q);
  assign fl_active = wait_run || in_xfer;
  assign wr_pulse  = is_wr_q && wait_run && (cnt != '0) && !wait_done;

  pcif_flash_port #(.DW_AW(DW_AW)) u_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (fl_active),
    .is_wr   (is_wr_q),
    .wr_pulse(wr_pulse),
    .hi      (hi_sel),
    .dw_addr (dw_q),
    .wdata   (wdata_q),
    .be_n    (be_q),
    .fl_addr (fl_addr),
    .fl_dq_o (fl_dq_o),
    .fl_dq_oe(fl_dq_oe),
    .fl_ce_n (fl_ce_n),
    .fl_oe_n (fl_oe_n),
    .fl_we_n (fl_we_n)
  );

  assign devsel_n = !(in_wait || in_xfer);
  assign trdy_n   = !in_xfer;
  assign stop_n   = !in_xfer;
  assign ad_oe    = in_xfer && !is_wr_q;
  assign ad_o     = place_word(rdata_q, hi_sel);

  // R3
  devsel_medium_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> $past(claim, 2));

  // R4
  trdy_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trdy_n) |-> $past(wait_done));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && irdy_n) |=> (!trdy_n && !stop_n && $stable(ad_o)));

  // R7
  release_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> (trdy_n && stop_n && devsel_n && !ad_oe));

endmodule

// File: tb/pcif_flash_bridge_tb.sv
`timescale 1ns/1ps
module pcif_flash_bridge_tb_top;

  localparam int LAT = 6;
  localparam logic [14:0] BASE = 15'h1A5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] win_base = BASE;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_i = '0;
  logic [31:0] ad_o;
  logic        ad_oe, devsel_n, trdy_n, stop_n;
  logic [15:0] fl_addr, fl_dq_o, fl_dq_i;
  logic        fl_dq_oe, fl_ce_n, fl_oe_n;
  logic [1:0]  fl_we_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit fin = 1'b0;

  logic [15:0] fmem    [0:255];
  logic [15:0] exp_mem [0:255];

  always #5 clk = ~clk;

  pcif_flash_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .win_base(win_base), .frame_n(frame_n),
    .irdy_n(irdy_n), .cbe_n(cbe_n), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .fl_addr(fl_addr),
    .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i), .fl_ce_n(fl_ce_n),
    .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  function automatic logic [15:0] seed(input int i);
    return 16'((i * 40503 + 4660) ^ (i << 9));
  endfunction

  // Behavioural flash: combinational read, write while a lane enable is low.
  assign fl_dq_i = (!fl_ce_n && !fl_oe_n) ? fmem[fl_addr[7:0]] : 16'hFFFF;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) fmem[i] <= seed(i);
    end else begin
      if (!fl_we_n[0]) fmem[fl_addr[7:0]][7:0]  <= fl_dq_o[7:0];
      if (!fl_we_n[1]) fmem[fl_addr[7:0]][15:8] <= fl_dq_o[15:8];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    fin = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // One initiator transaction with FRAME# held low to request a burst.
  task automatic xact(input bit wr, input logic [16:0] off, input logic [3:0] be_n,
                      input int dly, input logic [31:0] wd);
    int k, trdy_at, exp_t, lo_cnt0, lo_cnt1;
    bit done;
    bit hi;
    int idx;
    logic [1:0] lanes;
    logic [31:0] exp_rd;
    hi     = (be_n[1:0] == 2'b11);
    idx    = {off[8:2], hi};
    lanes  = hi ? ~be_n[3:2] : ~be_n[1:0];
    exp_rd = 32'(exp_mem[idx]) << (hi ? 16 : 0);
    exp_t  = wr ? (LAT + 2 + dly) : (LAT + 2);
    lo_cnt0 = 0; lo_cnt1 = 0;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1;
    ad_i = {BASE, off}; cbe_n = wr ? 4'b0111 : 4'b0110;
    @(negedge clk); k = 1;
    chk(devsel_n === 1'b1, "R3 devsel high one clock after address", 32'(devsel_n), 32'd1);
    cbe_n = be_n;
    ad_i  = wr ? wd : 32'h0;
    irdy_n = (dly == 0) ? 1'b0 : 1'b1;
    trdy_at = -1; done = 1'b0;
    while (!done && k < 100) begin
      @(negedge clk); k++;
      if (k == 2)
        chk(devsel_n === 1'b0, "R3 devsel low two clocks after address", 32'(devsel_n), 32'd0);
      if (ad_oe && trdy_n) chk(1'b0, "R8 AD driven without TRDY", 32'(ad_oe), 32'd0);
      if (stop_n !== trdy_n) chk(1'b0, "R5 STOP differs from TRDY", 32'(stop_n), 32'(trdy_n));
      if (wr) begin
        if (!fl_we_n[0]) lo_cnt0++;
        if (!fl_we_n[1]) lo_cnt1++;
      end
      if (trdy_at >= 0)
        chk(trdy_n === 1'b0, "R6 TRDY held during IRDY stall", 32'(trdy_n), 32'd0);
      if (!trdy_n) begin
        if (trdy_at < 0) begin
          trdy_at = k;
          chk(k == exp_t, "R4 TRDY latency", 32'(k), 32'(exp_t));
        end
        if (!wr) chk(ad_o === exp_rd && ad_oe === 1'b1, "R8 read data", ad_o, exp_rd);
      end
      if (k == 1 + dly) irdy_n = 1'b0;
      if (!trdy_n && !irdy_n) done = 1'b1;
    end
    @(negedge clk);
    chk({devsel_n, trdy_n, stop_n, ad_oe} === 4'b1110, "R7 release after transfer",
        32'({devsel_n, trdy_n, stop_n, ad_oe}), 32'hE);
    frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF;
    @(negedge clk);
    chk(devsel_n === 1'b1 && trdy_n === 1'b1, "R5 single transfer per transaction",
        32'({devsel_n, trdy_n}), 32'h3);
    if (wr) begin
      chk(lo_cnt0 == (lanes[0] ? LAT - 2 : 0), "R9 lane0 write pulse", 32'(lo_cnt0),
          32'(lanes[0] ? LAT - 2 : 0));
      chk(lo_cnt1 == (lanes[1] ? LAT - 2 : 0), "R9 lane1 write pulse", 32'(lo_cnt1),
          32'(lanes[1] ? LAT - 2 : 0));
      if (lanes[0]) exp_mem[idx][7:0]  = hi ? wd[23:16] : wd[7:0];
      if (lanes[1]) exp_mem[idx][15:8] = hi ? wd[31:24] : wd[15:8];
    end
  endtask

  task automatic no_claim(input logic [31:0] addr, input logic [3:0] cmd);
    bit seen;
    seen = 1'b0;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad_i = addr; cbe_n = cmd;
    @(negedge clk);
    cbe_n = 4'b0000; irdy_n = 1'b0;
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      if (devsel_n !== 1'b1 || fl_ce_n !== 1'b1 || fl_we_n !== 2'b11) seen = 1'b1;
    end
    chk(!seen, "R2 unclaimed cycle left alone", 32'(seen), 32'd0);
    frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!fin) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [3:0] pats [7];
    pats = '{4'b1110, 4'b1101, 4'b1011, 4'b0111, 4'b1100, 4'b0011, 4'b0000};
    for (int i = 0; i < 256; i++) exp_mem[i] = seed(i);
    repeat (3) @(negedge clk);
    // R1 during reset
    chk({devsel_n, trdy_n, stop_n, ad_oe, fl_ce_n, fl_oe_n, fl_we_n} === 8'b1110_1111,
        "R1 reset state", 32'({devsel_n, trdy_n, stop_n, ad_oe, fl_ce_n, fl_oe_n, fl_we_n}), 32'hEF);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({devsel_n, trdy_n, stop_n, ad_oe, fl_ce_n, fl_oe_n, fl_we_n} === 8'b1110_1111,
        "R1 idle after reset", 32'({devsel_n, trdy_n, stop_n, ad_oe, fl_ce_n, fl_oe_n, fl_we_n}), 32'hEF);

    // R8 read sweep over dwords, byte enable patterns and IRDY delays
    for (int a = 0; a < 16; a++)
      for (int p = 0; p < 7; p++)
        for (int d = 0; d < 2; d++)
          xact(1'b0, 17'(a * 4 + 17'h100), pats[p], d * 3, 32'h0);

    // R6 long IRDY stalls after TRDY
    for (int d = LAT + 3; d < LAT + 7; d++)
      xact(1'b0, 17'(d * 4), 4'b0011, d, 32'h0);

    // R9 writes with every lane pattern, then full-word readback
    for (int a = 0; a < 8; a++)
      for (int p = 0; p < 7; p++) begin
        xact(1'b1, 17'(a * 4), pats[p], (p % 3), 32'hA5000000 ^ 32'(a * 32'h01030507 + p * 32'h11111111));
        xact(1'b0, 17'(a * 4), 4'b1100, 0, 32'h0);
        xact(1'b0, 17'(a * 4), 4'b0011, 1, 32'h0);
      end

    // R2 every other command at the window, and misses on the base
    for (int c = 0; c < 16; c++)
      if (c != 6 && c != 7) no_claim({BASE, 17'h00010}, 4'(c));
    no_claim({BASE + 15'd1, 17'h00010}, 4'b0110);
    no_claim({BASE - 15'd1, 17'h00010}, 4'b0111);

    // R7 a claimed cycle right after unclaimed ones
    xact(1'b0, 17'h00010, 4'b1110, 0, 32'h0);

    summary();
    $finish;
  end

endmodule